// File: doc/BRIEF.md
# Clock Output Bank Stop Controller

This block sits behind a clock generator and decides, for each of five banks of paired clock outputs and for a true/complement feedback pair, whether the output runs or is stopped. It works on a fast sampling clock. The internal clock and the bypass reference clock arrive as sampled data levels. Every output is a registered copy of the selected source. A stop never cuts a pulse short: the channel waits until the source is at the stop level, then holds it there. A restart also waits for the source to be at that level, so the next transition is a normal edge of the source.

Each control comes from a pin OR-ed with one bit of an 8-bit control field. In the full configuration word, that field sits at word bits 52 to 59. Pins and field bits pass through two synchronizer stages before they are used, and so do the two source levels. A stopped output is either driven at a selectable static level or released through its own output-enable. The feedback pair stops only on power-down. Its complement output always stops at the level opposite to the true output.

Top module: `clkout_stop_ctrl`

## Requirements
- R1: While reset is high and for two clocks after it falls, every output-enable is low, all bank outputs and `fb_o` are 0, and `fb_n_o` is 1.
- R2: After the synchronizers have settled, a running output equals the selected source delayed by three clocks. The input is seen two clocks after it was applied, and the output register adds one more.
- R3: Bank b (both outputs) is disabled when `bank_dis_i[b]` is 1 or field bit b (word bit 52+b) is 1. It is enabled only when both are 0.
- R4: A running output that is being disabled keeps following the source until the source equals the stop level, and then freezes at that level. No output pulse is shorter than a source half-period.
- R5: A stopped output whose disable has been removed stays at the stop level until the source equals that level, and then follows the source again.
- R6: The stop level is set by field bit 6 (word bit 58). When that bit is 0, bank outputs and `fb_o` stop at 1 and `fb_n_o` stops at 0. When it is 1, all of these levels are inverted.
- R7: When `hold_i` is 1 or field bit 7 (word bit 59) is 1, a stopped output keeps its enable high. When both are 0, a stopped output's enable is low. A running output's enable is always high.
- R8: When `bypass_i` is 1 or field bit 5 (word bit 57) is 1, the source is `ref_clk_i`. Otherwise it is `pll_clk_i`.
- R9: When `pd_n_i` is 0, every output, including the feedback pair, is disabled.
- R10: `fb_n_o` is always the inverse of `fb_o`.
- R11: Bank disables have no effect on the feedback pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock for all registers |
| rst | input | 1 | Synchronous active-high reset |
| pll_clk_i | input | 1 | Internal clock level (sampled asynchronously) |
| ref_clk_i | input | 1 | Reference clock level used in bypass |
| bank_dis_i | input | 5 | Per-bank disable pins, 1 = disable |
| pd_n_i | input | 1 | Power-down, active low |
| bypass_i | input | 1 | Bypass pin, 1 = route reference clock |
| hold_i | input | 1 | Stop-mode pin, 1 = drive static level |
| cfg_i | input | 8 | Control field: [4:0] bank disable, [5] bypass, [6] stop level, [7] hold mode |
| bank_q_o | output | 10 | Bank outputs, bank b on bits 2b+1:2b |
| bank_oe_o | output | 10 | Output-enable for each bank output |
| fb_o | output | 1 | True feedback output |
| fb_n_o | output | 1 | Complement feedback output |
| fb_oe_o | output | 1 | Output-enable for the feedback pair |

## Verification
The pulse-width and frozen-output assertions assume that each source level holds for at least two sampling clocks between changes. The bench meets this by toggling the internal clock every two cycles and the reference every three. The same two assertions also assume that a change of stop level or of source selection can move an output at any time. A checker counter therefore mutes them for five cycles after such a change, and after reset. The stimulus changes the level bit or the bypass controls only in isolated steps, separated by long stretches of steady operation.

// File: rtl/cbs_pkg.sv
package cbs_pkg;
  typedef enum logic {CH_RUN = 1'b0, CH_STOP = 1'b1} ch_state_e;
  localparam int unsigned DEF_SYNC_STAGES = 2;
  localparam int unsigned DEF_BANKS       = 5;
endpackage

// File: rtl/cbs_sync.sv
module cbs_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cbs_decode.sv
module cbs_decode #(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned SETTLE    = 2,
  localparam int unsigned CTL_W    = NUM_BANKS + 3,
  localparam int unsigned CNT_W    = $clog2(SETTLE + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pll_s,
  input  logic                 ref_s,
  input  logic [NUM_BANKS-1:0] pin_dis_s,
  input  logic                 pd_n_s,
  input  logic                 byp_pin_s,
  input  logic                 hold_pin_s,
  input  logic [CTL_W-1:0]     ctl_s,
  output logic                 src_o,
  output logic                 lvl_o,
  output logic                 hold_o,
  output logic                 byp_o,
  output logic [NUM_BANKS-1:0] bank_dis_o,
  output logic                 fb_dis_o,
  output logic                 settled_o
);
  localparam int unsigned BYP_BIT  = NUM_BANKS;
  localparam int unsigned LVL_BIT  = NUM_BANKS + 1;
  localparam int unsigned HOLD_BIT = NUM_BANKS + 2;

  logic [CNT_W-1:0] settle_cnt;

  always_ff @(posedge clk) begin
    if (rst) settle_cnt <= '0;
    else if (settle_cnt != CNT_W'(SETTLE)) settle_cnt <= settle_cnt + 1'b1;
  end

  assign settled_o = (settle_cnt == CNT_W'(SETTLE));

  always_comb begin
    byp_o    = byp_pin_s | ctl_s[BYP_BIT];
    hold_o   = hold_pin_s | ctl_s[HOLD_BIT];
    lvl_o    = ~ctl_s[LVL_BIT];
    src_o    = byp_o ? ref_s : pll_s;
    fb_dis_o = ~pd_n_s;
    for (int b = 0; b < NUM_BANKS; b++) begin
      bank_dis_o[b] = pin_dis_s[b] | ctl_s[b] | ~pd_n_s;
    end
  end
endmodule

// File: rtl/cbs_stop_chan.sv
module cbs_stop_chan
  import cbs_pkg::*;
#(
  parameter bit INVERT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic settled_i,
  input  logic src_i,
  input  logic lvl_i,
  input  logic dis_i,
  input  logic hold_i,
  output logic q_o,
  output logic oe_o,
  output logic stopped_o
);
  ch_state_e state_q, state_d;
  logic      q_d, oe_d;
  logic      src_c, lvl_c;

  assign src_c = src_i ^ INVERT;
  assign lvl_c = lvl_i ^ INVERT;

  always_comb begin
    state_d = state_q;
    if (!settled_i) begin
      state_d = CH_STOP;
      q_d     = q_o;
      oe_d    = 1'b0;
    end else begin
      case (state_q)
        CH_RUN:  if (dis_i && (src_c == lvl_c)) state_d = CH_STOP;
        CH_STOP: if (!dis_i && (src_c == lvl_c)) state_d = CH_RUN;
        default: state_d = CH_STOP;
      endcase
      q_d  = (state_d == CH_RUN) ? src_c : lvl_c;
      oe_d = (state_d == CH_RUN) || hold_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= CH_STOP;
      q_o     <= INVERT;
      oe_o    <= 1'b0;
    end else begin
      state_q <= state_d;
      q_o     <= q_d;
      oe_o    <= oe_d;
    end
  end

  assign stopped_o = (state_q == CH_STOP);
endmodule

// File: rtl/clkout_stop_ctrl.sv
module clkout_stop_ctrl #(
  parameter int unsigned NUM_BANKS   = cbs_pkg::DEF_BANKS,
  parameter int unsigned SYNC_STAGES = cbs_pkg::DEF_SYNC_STAGES,
  localparam int unsigned CTL_W      = NUM_BANKS + 3,
  localparam int unsigned OUT_W      = 2 * NUM_BANKS,
  localparam int unsigned SYNC_W     = 2 * NUM_BANKS + 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pll_clk_i,
  input  logic                 ref_clk_i,
  input  logic [NUM_BANKS-1:0] bank_dis_i,
  input  logic                 pd_n_i,
  input  logic                 bypass_i,
  input  logic                 hold_i,
  input  logic [CTL_W-1:0]     cfg_i,
  output logic [OUT_W-1:0]     bank_q_o,
  output logic [OUT_W-1:0]     bank_oe_o,
  output logic                 fb_o,
  output logic                 fb_n_o,
  output logic                 fb_oe_o
);
  logic [SYNC_W-1:0]    async_vec, sync_vec;
  logic                 pll_s, ref_s, pd_n_s, byp_pin_s, hold_pin_s;
  logic [NUM_BANKS-1:0] pin_dis_s, bank_dis;
  logic [CTL_W-1:0]     ctl_s;
  logic                 src, lvl_s, hold_s, byp_s, fb_dis, settled;
  logic [OUT_W-1:0]     chan_stopped;
  logic                 fb_stopped, fbn_stopped, fbn_oe;

  assign async_vec = {pll_clk_i, ref_clk_i, bank_dis_i, pd_n_i, bypass_i, hold_i, cfg_i};

  cbs_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(async_vec), .q_o(sync_vec)
  );

  assign {pll_s, ref_s, pin_dis_s, pd_n_s, byp_pin_s, hold_pin_s, ctl_s} = sync_vec;

  cbs_decode #(.NUM_BANKS(NUM_BANKS), .SETTLE(SYNC_STAGES)) u_dec (
    .clk(clk), .rst(rst),
    .pll_s(pll_s), .ref_s(ref_s), .pin_dis_s(pin_dis_s), .pd_n_s(pd_n_s),
    .byp_pin_s(byp_pin_s), .hold_pin_s(hold_pin_s), .ctl_s(ctl_s),
    .src_o(src), .lvl_o(lvl_s), .hold_o(hold_s), .byp_o(byp_s),
    .bank_dis_o(bank_dis), .fb_dis_o(fb_dis), .settled_o(settled)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar k = 0; k < 2; k++) begin : g_pin
      cbs_stop_chan #(.INVERT(1'b0)) u_chan (
        .clk(clk), .rst(rst), .settled_i(settled), .src_i(src), .lvl_i(lvl_s),
        .dis_i(bank_dis[b]), .hold_i(hold_s),
        .q_o(bank_q_o[2*b+k]), .oe_o(bank_oe_o[2*b+k]),
        .stopped_o(chan_stopped[2*b+k])
      );
    end
  end

  cbs_stop_chan #(.INVERT(1'b0)) u_fb (
    .clk(clk), .rst(rst), .settled_i(settled), .src_i(src), .lvl_i(lvl_s),
    .dis_i(fb_dis), .hold_i(hold_s),
    .q_o(fb_o), .oe_o(fb_oe_o), .stopped_o(fb_stopped)
  );

  cbs_stop_chan #(.INVERT(1'b1)) u_fbn (
    .clk(clk), .rst(rst), .settled_i(settled), .src_i(src), .lvl_i(lvl_s),
    .dis_i(fb_dis), .hold_i(hold_s),
    .q_o(fb_n_o), .oe_o(fbn_oe), .stopped_o(fbn_stopped)
  );
endmodule

// File: rtl/cbs_checker.sv
module cbs_checker #(
  parameter int unsigned NUM_BANKS = 5,
  localparam int unsigned OUT_W    = 2 * NUM_BANKS
) (
  input logic             clk,
  input logic             rst,
  input logic [OUT_W-1:0] bank_q,
  input logic [OUT_W-1:0] bank_oe,
  input logic             fb,
  input logic             fb_n,
  input logic             fb_oe,
  input logic             fb_stopped,
  input logic             fbn_stopped,
  input logic             hold_s,
  input logic             lvl_s,
  input logic             byp_s,
  input logic             settled,
  input logic [OUT_W-1:0] chan_stopped
);
  logic [2:0] quiet;
  logic       lvl_d, byp_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet <= '0;
      lvl_d <= 1'b0;
      byp_d <= 1'b0;
    end else begin
      lvl_d <= lvl_s;
      byp_d <= byp_s;
      if ((lvl_s != lvl_d) || (byp_s != byp_d)) quiet <= '0;
      else if (quiet != 3'd7) quiet <= quiet + 3'd1;
    end
  end

  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bank_oe == '0 && !fb_oe));

  assert_fb_inverse_R10: assert property (@(posedge clk) disable iff (rst)
    (fb_n == ~fb) && (fb_stopped == fbn_stopped));

  assert_fb_tristate_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(settled) && !fb_oe) |-> !$past(hold_s));

  for (genvar i = 0; i < OUT_W; i++) begin : g_out
    assert_no_runt_R4: assert property (@(posedge clk) disable iff (rst)
      (quiet >= 3'd5 && bank_q[i] != $past(bank_q[i])) |=> $stable(bank_q[i]));

    assert_frozen_R4: assert property (@(posedge clk) disable iff (rst)
      ($past(chan_stopped[i]) && chan_stopped[i] && quiet >= 3'd5) |-> $stable(bank_q[i]));

    assert_tristate_R7: assert property (@(posedge clk) disable iff (rst)
      ($past(settled) && !bank_oe[i]) |-> !$past(hold_s));
  end
endmodule

bind clkout_stop_ctrl cbs_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk(clk), .rst(rst), .bank_q(bank_q_o), .bank_oe(bank_oe_o),
  .fb(fb_o), .fb_n(fb_n_o), .fb_oe(fb_oe_o),
  .fb_stopped(fb_stopped), .fbn_stopped(fbn_stopped),
  .hold_s(hold_s), .lvl_s(lvl_s), .byp_s(byp_s), .settled(settled),
  .chan_stopped(chan_stopped)
);

// File: tb/clkout_stop_ctrl_test.sv
`timescale 1ns/1ps
module clkout_stop_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pll_clk_i = 1'b0, ref_clk_i = 1'b0;
  logic [4:0] bank_dis_i = '0;
  logic       pd_n_i = 1'b1, bypass_i = 1'b0, hold_i = 1'b1;
  logic [7:0] cfg_i = '0;
  logic [9:0] bank_q_o, bank_oe_o;
  logic       fb_o, fb_n_o, fb_oe_o;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  bit    cmp_en = 1'b0, done = 1'b0;
  string tag = "R1";

  always #4 clk = ~clk;

  clkout_stop_ctrl uut (
    .clk(clk), .rst(rst), .pll_clk_i(pll_clk_i), .ref_clk_i(ref_clk_i),
    .bank_dis_i(bank_dis_i), .pd_n_i(pd_n_i), .bypass_i(bypass_i), .hold_i(hold_i),
    .cfg_i(cfg_i), .bank_q_o(bank_q_o), .bank_oe_o(bank_oe_o),
    .fb_o(fb_o), .fb_n_o(fb_n_o), .fb_oe_o(fb_oe_o)
  );

  // behavioural reference: inputs take effect two edges after capture
  logic [17:0] hist[$];
  bit m_stop[11], m_q[11], m_oe[11];
  int settle_n = 0;

  always @(posedge clk) begin
    logic [17:0] u;
    bit src, lvl, hld, dis;
    if (rst) begin
      hist = {18'd0, 18'd0};
      settle_n = 0;
      for (int j = 0; j < 11; j++) begin m_stop[j] = 1; m_q[j] = 0; m_oe[j] = 0; end
    end else begin
      hist.push_back({pll_clk_i, ref_clk_i, bank_dis_i, pd_n_i, bypass_i, hold_i, cfg_i});
      u = hist.pop_front();
      if (settle_n < 2) begin
        settle_n++;
        for (int j = 0; j < 11; j++) begin m_stop[j] = 1; m_oe[j] = 0; end
      end else begin
        src = (u[9] | u[5]) ? u[16] : u[17];
        lvl = !u[6];
        hld = u[8] | u[7];
        for (int j = 0; j < 11; j++) begin
          dis = !u[10];
          if (j < 10) dis = dis | u[11 + j/2] | u[j/2];
          if (!m_stop[j] && dis && src == lvl) m_stop[j] = 1;
          else if (m_stop[j] && !dis && src == lvl) m_stop[j] = 0;
          m_q[j]  = m_stop[j] ? lvl : src;
          m_oe[j] = !m_stop[j] || hld;
        end
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      logic [22:0] exp_v;
      @(negedge clk);
      if (cmp_en) begin
        exp_v[9:0] = '0; exp_v[19:10] = '0;
        for (int j = 0; j < 10; j++) begin exp_v[j] = m_q[j]; exp_v[10+j] = m_oe[j]; end
        exp_v[22:20] = {m_oe[10], !m_q[10], m_q[10]};
        check(tag, 32'({fb_oe_o, fb_n_o, fb_o, bank_oe_o, bank_q_o}), 32'(exp_v));
      end
      cyc++;
      pll_clk_i = 1'((cyc / 2) % 2);
      ref_clk_i = 1'((cyc / 3) % 2);
    end
  endtask

  initial begin
    step(3);
    cmp_en = 1'b1;
    step(3);
    check("R1", 32'({bank_oe_o, fb_oe_o, fb_o, fb_n_o}), 32'({10'd0, 1'b0, 1'b0, 1'b1}));
    rst = 1'b0;
    step(2);
    check("R1", 32'({bank_oe_o, fb_oe_o}), 32'd0);
    tag = "R2"; step(40);
    tag = "R3"; bank_dis_i = 5'b01010; step(40);
    check("R3", 32'({bank_q_o[7:6], bank_q_o[3:2], bank_oe_o[7:6]}), 32'b11_11_11);
    tag = "R11"; step(12);
    tag = "R3"; bank_dis_i = '0; cfg_i[4:0] = 5'b10001; step(40);
    tag = "R5"; cfg_i[4:0] = '0; step(40);
    tag = "R6"; cfg_i[6] = 1'b1; step(10);
    cfg_i[2] = 1'b1; step(30);
    check("R6", 32'({bank_q_o[5:4], bank_oe_o[5:4]}), 32'b00_11);
    tag = "R7"; hold_i = 1'b0; step(30);
    check("R7", 32'({bank_oe_o[5:4], bank_oe_o[1:0]}), 32'b00_11);
    cfg_i[7] = 1'b1; step(20);
    check("R7", 32'(bank_oe_o[5:4]), 32'b11);
    cfg_i[7] = 1'b0; cfg_i[6] = 1'b0; cfg_i[2] = 1'b0; step(30);
    tag = "R8"; bypass_i = 1'b1; step(40);
    bypass_i = 1'b0; cfg_i[5] = 1'b1; step(40);
    cfg_i[5] = 1'b0; step(20);
    tag = "R9"; pd_n_i = 1'b0; step(40);
    check("R9", 32'({bank_oe_o, fb_oe_o, fb_o, fb_n_o}), 32'({10'd0, 1'b0, 1'b1, 1'b0}));
    hold_i = 1'b1; step(20);
    check("R9", 32'({bank_q_o, fb_o, fb_n_o}), 32'({10'h3FF, 1'b1, 1'b0}));
    tag = "R4"; pd_n_i = 1'b1; step(30);
    bank_dis_i = 5'b11111; step(7); bank_dis_i = '0; step(9);
    tag = "R10"; cfg_i[6] = 1'b1; step(20);
    pd_n_i = 1'b0; step(20);
    check("R10", 32'({fb_o, fb_n_o}), 32'b01);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule